// File: doc/BRIEF.md
# Parallel EPROM Read Cycle Controller

This block sits on the host side of an asynchronous byte-wide EPROM that has 19 address lines, an active-low chip select and an active-low output gate. A client raises a request with an address while the controller is not busy. The controller then drives the address, selects the chip, opens the output gate, and waits until every access delay of the memory has run out. It captures the byte and hands it back with a one-cycle valid pulse. Before the next access it closes the gate and leaves the bus alone for the output-float interval.

All waits are whole clock cycles. They come from the clock period and the speed grade through ceiling division, so no timing minimum is ever shortened. Between reads the chip stays selected, so that a following read does not have to pay the chip-select delay again. After a configurable number of idle cycles, or at once on a standby request, the chip is deselected into its low-power state.

Top module: `prom_read_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, mem_ce_n and mem_oe_n are 1 and busy and rvalid are 0.
- R2: A request seen at a clock edge while busy is 0 drives mem_addr to addr, mem_ce_n to 0 and mem_oe_n to 0, and raises busy, all from that edge.
- R3: The byte is captured at the first edge that satisfies all three waits: ceil(tAA/T) cycles since the address changed, ceil(tOE/T) cycles since the gate opened, and ceil(tCS/T) cycles since the chip was selected. The fast grade (SPEED_GRADE=0) uses tAA=tCS=90 ns and tOE=40 ns. The slow grade (1) uses 120, 120 and 55 ns. With the defaults the capture comes 5 cycles after acceptance.
- R4: At the capture edge rvalid goes to 1 for exactly one cycle, rdata takes the value on mem_dq, and mem_oe_n returns to 1.
- R5: After the gate closes, busy stays at 1 for ceil(30 ns/T) more cycles, so the gate never reopens less than 30 ns after it closed.
- R6: A request or standby request made while busy is 1 is ignored: mem_addr, the strobes and the number of rvalid pulses are unchanged.
- R7: mem_addr changes only when a request is accepted. It is stable while mem_oe_n is 0, and successive address changes are at least tAA apart.
- R8: When busy has been 0 with the chip selected for IDLE_LIMIT cycles and no request has come, mem_ce_n goes to 1. mem_oe_n is never 0 while mem_ce_n is 1.
- R9: A standby request while idle and selected sets mem_ce_n to 1 at the next edge. A request at the same edge wins: a read starts instead.
- R10: When a read follows another before standby, mem_ce_n stays at 0 in between. The chip-select wait counts from the earlier select edge and does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request, taken when busy is 0 |
| addr | input | 19 | Byte address of the request |
| standby_req | input | 1 | Ask to deselect the chip while idle |
| busy | output | 1 | A read or float interval is in progress |
| rdata | output | 8 | Captured byte |
| rvalid | output | 1 | One-cycle pulse marking new rdata |
| mem_addr | output | 19 | Address lines to the memory |
| mem_ce_n | output | 1 | Chip select to the memory, active low |
| mem_oe_n | output | 1 | Output gate to the memory, active low |
| mem_dq | input | 8 | Data lines from the memory |

## Verification
The bench models the memory in nanoseconds and presents a junk byte until every access delay has run out. A controller that captures even one cycle early returns that junk instead of the stored byte. It times the gate-closed interval and the spacing of address changes in nanoseconds, which exposes a float interval or a read cycle that is too short. It fires requests and standby requests in the middle of a read, which shows up any controller that takes them. It counts idle cycles up to deselection, sends a request together with a standby request, and runs back-to-back reads. A design that re-pulses the chip select or lets the idle count run one cycle off shows up as a strobe mismatch against the cycle model.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    typedef enum logic [1:0] {
        PH_STANDBY  = 2'd0,
        PH_SELECTED = 2'd1,
        PH_ACCESS   = 2'd2,
        PH_FLOAT    = 2'd3
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
    } strobe_t;

    localparam int GRADE_FAST = 0;
    localparam int GRADE_SLOW = 1;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // address-to-data delay, also the minimum read cycle
    function automatic int t_addr_ns(input int grade);
        return (grade == GRADE_FAST) ? 90 : 120;
    endfunction

    function automatic int t_sel_ns(input int grade);
        return (grade == GRADE_SLOW) ? 120 : 90;
    endfunction

    function automatic int t_gate_ns(input int grade);
        return (grade == GRADE_SLOW) ? 55 : 40;
    endfunction

    function automatic int t_float_ns(input int grade);
        return (grade == GRADE_SLOW) ? 30 : 30;
    endfunction

endpackage

// File: rtl/prom_down_timer.sv
module prom_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (en && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == W'(1));

    // R3: an expired timer stays expired until reloaded
    a_r3_timer_stays_zero: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/prom_ce_age.sv
module prom_ce_age #(
    parameter int W   = 4,
    parameter int SAT = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce_n,
    output logic [W-1:0] age
);
    always_ff @(posedge clk) begin
        if (rst || ce_n)
            age <= '0;
        else if (age != W'(SAT))
            age <= age + 1'b1;
    end

    // R10: the select age restarts only when the chip is deselected
    a_r10_age_clears: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (age == '0));
    a_r10_age_grows: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && age != W'(SAT)) |=> (age == $past(age) + 1'b1));
endmodule

// File: rtl/prom_read_ctrl.sv
module prom_read_ctrl
    import prom_rd_pkg::*;
#(
    parameter int CLK_NS      = 20,
    parameter int SPEED_GRADE = 0,
    parameter int IDLE_LIMIT  = 8,
    parameter int AW          = 19,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic          standby_req,
    output logic          busy,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    input  logic [DW-1:0] mem_dq
);
    localparam int N_ADDR = ceil_div(t_addr_ns(SPEED_GRADE), CLK_NS);
    localparam int N_SEL  = ceil_div(t_sel_ns(SPEED_GRADE), CLK_NS);
    localparam int N_GATE = ceil_div(t_gate_ns(SPEED_GRADE), CLK_NS);
    localparam int N_FLT  = ceil_div(t_float_ns(SPEED_GRADE), CLK_NS);
    localparam int CNT_W  = $clog2(max3(N_ADDR, N_SEL, max3(N_GATE, N_FLT, 1)) + 1) + 1;
    localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);

    phase_e        phase_q;
    strobe_t       strb_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;

    logic             accept;
    logic             phase_load, phase_last, idle_last;
    logic [CNT_W-1:0] phase_val, wait_need, ce_age;
    int               sel_left;

    assign accept = req && (phase_q == PH_STANDBY || phase_q == PH_SELECTED);

    prom_ce_age #(.W(CNT_W), .SAT(N_SEL)) u_age (
        .clk(clk), .rst(rst), .ce_n(strb_q.ce_n), .age(ce_age)
    );

    // remaining select wait, measured from the acceptance edge
    always_comb begin
        if (strb_q.ce_n)
            sel_left = N_SEL;
        else if (int'(ce_age) + 1 >= N_SEL)
            sel_left = 0;
        else
            sel_left = N_SEL - int'(ce_age) - 1;
        wait_need = CNT_W'(max3(N_ADDR, N_GATE, sel_left));
    end

    assign phase_load = accept || (phase_q == PH_ACCESS && phase_last);
    assign phase_val  = accept ? wait_need : CNT_W'(N_FLT);

    prom_down_timer #(.W(CNT_W)) u_phase (
        .clk(clk), .rst(rst), .load(phase_load), .load_val(phase_val),
        .en(1'b1), .last(phase_last)
    );

    prom_down_timer #(.W(IDLE_W)) u_idle (
        .clk(clk), .rst(rst),
        .load(phase_q == PH_FLOAT && phase_last),
        .load_val(IDLE_W'(IDLE_LIMIT)),
        .en(phase_q == PH_SELECTED), .last(idle_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_STANDBY;
            strb_q   <= '{ce_n: 1'b1, oe_n: 1'b1};
            addr_q   <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            case (phase_q)
                PH_STANDBY, PH_SELECTED: begin
                    if (req) begin
                        addr_q  <= addr;
                        strb_q  <= '{ce_n: 1'b0, oe_n: 1'b0};
                        phase_q <= PH_ACCESS;
                    end else if (phase_q == PH_SELECTED && (standby_req || idle_last)) begin
                        strb_q.ce_n <= 1'b1;
                        phase_q     <= PH_STANDBY;
                    end
                end
                PH_ACCESS: begin
                    if (phase_last) begin
                        rdata_q     <= mem_dq;
                        rvalid_q    <= 1'b1;
                        strb_q.oe_n <= 1'b1;
                        phase_q     <= PH_FLOAT;
                    end
                end
                PH_FLOAT: begin
                    if (phase_last)
                        phase_q <= PH_SELECTED;
                end
                default: phase_q <= PH_STANDBY;
            endcase
        end
    end

    assign busy     = (phase_q == PH_ACCESS) || (phase_q == PH_FLOAT);
    assign rdata    = rdata_q;
    assign rvalid   = rvalid_q;
    assign mem_addr = addr_q;
    assign mem_ce_n = strb_q.ce_n;
    assign mem_oe_n = strb_q.oe_n;

    // cycles the gate has been closed, saturating, for the float check
    logic [CNT_W-1:0] gate_shut_q;
    always_ff @(posedge clk) begin
        if (rst)
            gate_shut_q <= CNT_W'(N_FLT);
        else if (!mem_oe_n)
            gate_shut_q <= '0;
        else if (gate_shut_q != CNT_W'(N_FLT))
            gate_shut_q <= gate_shut_q + 1'b1;
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);
    a_r4_gate_closes: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $rose(mem_oe_n));
    a_r5_float_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> (gate_shut_q >= CNT_W'(N_FLT)));
    a_r6_busy_holds_addr: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mem_addr));
    a_r7_addr_steady: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |=> (mem_oe_n || $stable(mem_addr)));
    a_r8_gate_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);
    a_r2_accept_opens: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> (busy && !mem_ce_n && !mem_oe_n));
endmodule

// File: tb/prom_read_ctrl_test.sv
`timescale 1ns/1ps
module prom_read_ctrl_test;
    localparam int CLK_NS = 20;
    localparam int IDLE   = 8;
    localparam int TAA = 90, TCS = 90, TOE = 40, TFL = 30;
    localparam int NA = (TAA + CLK_NS - 1) / CLK_NS;
    localparam int NC = (TCS + CLK_NS - 1) / CLK_NS;
    localparam int NO = (TOE + CLK_NS - 1) / CLK_NS;
    localparam int NF = (TFL + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [18:0] addr = '0;
    logic        standby_req = 1'b0;
    logic        busy, rvalid, mem_ce_n, mem_oe_n;
    logic [7:0]  rdata;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq = 8'hEE;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    prom_read_ctrl #(.CLK_NS(CLK_NS), .SPEED_GRADE(0), .IDLE_LIMIT(IDLE),
                     .AW(19), .DW(8)) uut (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .standby_req(standby_req),
        .busy(busy), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    function automatic logic [7:0] rom(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b01101};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // memory model in nanoseconds: junk until every delay has elapsed
    real t_a = -1000.0, t_c = -1000.0, t_o = -1000.0, t_rise = -1000.0;
    bit  ce_rose = 0;
    always @(mem_addr) begin
        chk("R7", "address change spacing ok", ($realtime - t_a >= TAA), 1);
        t_a = $realtime;
    end
    always @(negedge mem_ce_n) t_c = $realtime;
    always @(posedge mem_ce_n) ce_rose = 1;
    always @(posedge mem_oe_n) t_rise = $realtime;
    always @(negedge mem_oe_n) begin
        chk("R5", "gate closed >= float time", ($realtime - t_rise >= TFL), 1);
        t_o = $realtime;
    end
    initial begin
        #0.5;
        forever begin
            if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 &&
                $realtime - t_a >= TAA && $realtime - t_c >= TCS &&
                $realtime - t_o >= TOE)
                mem_dq = rom(mem_addr);
            else
                mem_dq = 8'hEE;
            #1;
        end
    end

    // cycle reference model built on edge indices
    int e = 0, m_mode = 0, ce_fall = 0, samp = 0, free_e = 0;
    logic m_ce = 1, m_oe = 1, m_busy = 0, m_rv = 0;
    logic [7:0]  m_rd = '0;
    logic [18:0] m_addr = '0;
    always @(posedge clk) begin
        if (rst) begin
            e = 0; m_mode = 0; m_ce = 1; m_oe = 1; m_busy = 0; m_rv = 0;
            m_rd = '0; m_addr = '0;
        end else begin
            e++;
            m_rv = 0;
            if (m_mode <= 1) begin
                if (req) begin
                    m_addr = addr;
                    if (m_ce) ce_fall = e;
                    m_ce = 0; m_oe = 0; m_busy = 1; m_mode = 2;
                    samp = e + NA;
                    if (e + NO > samp) samp = e + NO;
                    if (ce_fall + NC > samp) samp = ce_fall + NC;
                end else if (m_mode == 1 && (standby_req || e == free_e + IDLE)) begin
                    m_ce = 1; m_mode = 0;
                end
            end else if (m_mode == 2) begin
                if (e == samp) begin
                    m_rd = rom(m_addr); m_rv = 1; m_oe = 1;
                    free_e = e + NF; m_mode = 3;
                end
            end else if (e == free_e) begin
                m_mode = 1; m_busy = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7", "mem_addr", mem_addr, m_addr);
            chk("R8", "mem_ce_n", mem_ce_n, m_ce);
            chk("R3", "mem_oe_n", mem_oe_n, m_oe);
            chk("R5", "busy", busy, m_busy);
            chk("R4", "rvalid", rvalid, m_rv);
            chk("R4", "rdata", rdata, m_rd);
        end
    end

    task automatic run_read(input logic [18:0] a, input bit with_sby, input bit poke);
        int n;
        while (busy) @(negedge clk);
        #1 req = 1; addr = a; standby_req = with_sby;
        @(negedge clk);
        #1 req = 0; standby_req = 0;
        chk("R2", "addr driven", mem_addr, a);
        chk("R2", "strobes low", {mem_ce_n, mem_oe_n}, 2'b00);
        chk("R2", "busy raised", busy, 1);
        n = 0;
        while (!rvalid) begin
            @(negedge clk);
            n++;
            if (poke && n == 1) begin req = 1; standby_req = 1; addr = a ^ 19'h5A5A5; end
            else begin req = 0; standby_req = 0; end
        end
        req = 0; standby_req = 0;
        chk("R3", "cycles to capture", n, NA);
        chk("R4", "captured byte", rdata, rom(a));
        if (poke) chk("R6", "address kept despite request", mem_addr, a);
        n = 0;
        while (busy) begin @(negedge clk); n++; end
        chk("R5", "float cycles", n, NF);
    endtask

    initial begin
        int q;
        repeat (3) @(negedge clk);
        chk("R1", "strobes in reset", {mem_ce_n, mem_oe_n}, 2'b11);
        chk("R1", "busy/rvalid in reset", {busy, rvalid}, 2'b00);
        #1 rst = 0;
        @(negedge clk);
        chk("R1", "strobes after reset", {mem_ce_n, mem_oe_n}, 2'b11);
        chk("R1", "busy after reset", busy, 0);

        run_read(19'h00000, 0, 0);
        q = 0;
        while (mem_ce_n == 1'b0) begin @(negedge clk); q++; end
        chk("R8", "idle cycles to standby", q, IDLE);
        chk("R8", "gate closed in standby", mem_oe_n, 1);

        run_read(19'h7FFFF, 0, 0);
        ce_rose = 0;
        run_read(19'h12345, 0, 0);
        chk("R10", "select held between reads", ce_rose, 0);

        run_read(19'h2AAAA, 0, 1);
        repeat (2) @(negedge clk);
        ce_rose = 0;
        run_read(19'h55555, 0, 0);
        chk("R10", "select held after short idle", ce_rose, 0);

        #1 standby_req = 1;
        @(negedge clk);
        #1 standby_req = 0;
        chk("R9", "standby request deselects", mem_ce_n, 1);

        run_read(19'h0F0F0, 0, 0);
        run_read(19'h3C3C3, 1, 0);
        chk("R9", "request beat standby request", mem_ce_n, 0);

        for (int i = 0; i < 8; i++) begin
            run_read(19'((i * 19'h0B3C5) ^ (i << 11)), 0, (i % 3) == 1);
            repeat (i) @(negedge clk);
        end
        repeat (IDLE + 4) @(negedge clk);
        chk("R8", "standby after final idle", mem_ce_n, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule